// File: doc/BRIEF.md
# Transparent-Mode Receive Character Filter for a Byte-Synchronous Link

This block sits between a synchronous character deserializer and the receive buffer writer of a byte-synchronous link controller running in transparent mode. For each received character it decides whether the character goes into the receive buffer and whether it counts toward the block check sequence. It also reports whether the character hit the programmable control-character table and whether the buffer has to be closed, with or without an escape-follow error.

The block recognises two programmable special characters. The first is an idle/fill character (SYNC). The second is an escape character (DLE). Each has its own enable bit. An enabled escape character opens a two-character sequence. The character after it is then classified separately: it may be a fill to drop, a literal escape to keep, a control character looked up in an eight-entry table, or an illegal follower that closes the buffer with an error. Characters are compared on all bits, so with 7-bit codes plus parity the programmed values must carry the parity bit. One verdict is produced per strobe and registered, so it appears for one clock, one clock after the strobe.

Top module: `bisync_rx_filter`

## Requirements
- R1: An ordinary character outside an escape sequence yields `write_en` and `bcs_include` high for one clock, one clock after its strobe, with `out_data` equal to the character.
- R2: Outside an escape sequence, with `sync_enable` set, a character equal to `sync_value` is dropped: `write_en` and `bcs_include` stay low.
- R3: Outside an escape sequence, with `dle_enable` set and the character not taken by R2, a character equal to `dle_value` is dropped, excluded from the check sequence, and arms the follow state.
- R4: In the follow state, a character equal to `sync_value` is dropped and excluded, whatever the state of `sync_enable`.
- R5: In the follow state, a character equal to `dle_value` is written and included.
- R6: In the follow state, any other character is compared with every valid table entry, where entry i is `ctrl_value[i*8 +: 8]`. On a hit, `ctrl_match`, `write_en` and `bcs_include` go high, and `close_buffer` equals `ctrl_close[i]` (1 = close, 0 = continue). The lowest matching index wins.
- R7: In the follow state, a character that is not a SYNC value, not a DLE value and not a valid table entry raises `close_buffer` and `dle_follow_error`, with `write_en` and `bcs_include` low.
- R8: With `dle_enable` clear, a DLE-valued character is ordinary data. With `sync_enable` clear, a SYNC-valued character outside an escape sequence is ordinary data.
- R9: Comparisons cover all 8 bits. A character that differs from a programmed value only in bit 7 does not match it.
- R10: Without an accepted strobe, all five verdict outputs are low in the following clock.
- R11: The follow state ends after one follow character. It is cleared whenever `hunt_mode` is high. Strobes that arrive while `hunt_mode` is high produce no verdict.
- R12: A low `rst_n` at a clock edge clears all verdict outputs, `out_data` and the follow state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hunt_mode | input | 1 | Receiver is hunting for synchronisation |
| char_valid | input | 1 | Strobe: `char_data` holds a new character |
| char_data | input | CHAR_W | Received character |
| dle_enable | input | 1 | Escape character recognition enabled |
| dle_value | input | CHAR_W | Escape character value |
| sync_enable | input | 1 | Fill character stripping enabled |
| sync_value | input | CHAR_W | Fill character value |
| ctrl_valid | input | CTRL_DEPTH | Per-entry valid bits of the control table |
| ctrl_value | input | CTRL_DEPTH*CHAR_W | Packed control table values, entry i at bits i*CHAR_W upward |
| ctrl_close | input | CTRL_DEPTH | Per-entry action: 1 close buffer, 0 write and continue |
| out_data | output | CHAR_W | Character belonging to the current verdict |
| write_en | output | 1 | Write the character to the buffer |
| bcs_include | output | 1 | Include the character in the block check sequence |
| close_buffer | output | 1 | Close the current buffer |
| dle_follow_error | output | 1 | Illegal character after an escape |
| ctrl_match | output | 1 | Follow character matched a control table entry |

## Verification
The bench builds the block with its defaults, 8-bit characters and eight table entries. This makes every entry reachable: the bench programs the last entry, a disabled entry whose value would otherwise hit, and two entries with the same value but opposite actions, so the lowest-index rule is visible at the ports. With 8-bit characters the bench can also present values that differ from the SYNC and DLE values only in bit 7, which exercises the parity-bit comparison rule.

// File: rtl/bisync_rx_filter_pkg.sv
package bisync_rx_filter_pkg;

  typedef struct packed {
    logic keep;
    logic bcs;
    logic close;
    logic ferr;
    logic cmatch;
  } verdict_t;

  localparam verdict_t VERDICT_NONE = '0;

  function automatic verdict_t mk_verdict(input logic keep, input logic bcs,
                                          input logic close, input logic ferr,
                                          input logic cmatch);
    verdict_t v;
    v.keep   = keep;
    v.bcs    = bcs;
    v.close  = close;
    v.ferr   = ferr;
    v.cmatch = cmatch;
    return v;
  endfunction

  function automatic logic same_char(input logic [15:0] a, input logic [15:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/bisync_ctrl_table.sv
module bisync_ctrl_table #(
  parameter int CHAR_W     = 8,
  parameter int CTRL_DEPTH = 8
) (
  input  logic [CHAR_W-1:0]            char_data,
  input  logic [CTRL_DEPTH-1:0]        ctrl_valid,
  input  logic [CTRL_DEPTH*CHAR_W-1:0] ctrl_value,
  input  logic [CTRL_DEPTH-1:0]        ctrl_close,
  output logic                         tbl_hit,
  output logic                         tbl_close
);
  localparam int IDX_W = (CTRL_DEPTH > 1) ? $clog2(CTRL_DEPTH) : 1;

  logic [CTRL_DEPTH-1:0] entry_hit;
  logic [IDX_W-1:0]      first_idx;

  for (genvar g = 0; g < CTRL_DEPTH; g++) begin : g_entry
    assign entry_hit[g] = ctrl_valid[g] &&
                          (ctrl_value[g*CHAR_W +: CHAR_W] == char_data);
  end

  function automatic logic [IDX_W-1:0] lowest_set(input logic [CTRL_DEPTH-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = CTRL_DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  assign first_idx = lowest_set(entry_hit);
  assign tbl_hit   = |entry_hit;
  assign tbl_close = tbl_hit && ctrl_close[first_idx];

endmodule

// File: rtl/bisync_char_classify.sv
module bisync_char_classify
  import bisync_rx_filter_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              follow,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              dle_enable,
  input  logic [CHAR_W-1:0] dle_value,
  input  logic              sync_enable,
  input  logic [CHAR_W-1:0] sync_value,
  input  logic              tbl_hit,
  input  logic              tbl_close,
  output verdict_t          verdict,
  output logic              arm_req
);
  logic is_sync;
  logic is_dle;

  assign is_sync = (char_data == sync_value);
  assign is_dle  = (char_data == dle_value);

  always_comb begin
    verdict = VERDICT_NONE;
    arm_req = 1'b0;
    if (!follow) begin
      if (sync_enable && is_sync) begin
        verdict = VERDICT_NONE;
      end else if (dle_enable && is_dle) begin
        verdict = VERDICT_NONE;
        arm_req = 1'b1;
      end else begin
        verdict = mk_verdict(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      end
    end else begin
      if (is_sync) begin
        verdict = VERDICT_NONE;
      end else if (is_dle) begin
        verdict = mk_verdict(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      end else if (tbl_hit) begin
        verdict = mk_verdict(1'b1, 1'b1, tbl_close, 1'b0, 1'b1);
      end else begin
        verdict = mk_verdict(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      end
    end
  end

endmodule

// File: rtl/bisync_follow_state.sv
module bisync_follow_state (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic arm,
  input  logic consume,
  output logic follow_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       follow_q <= 1'b0;
    else if (hunt)    follow_q <= 1'b0;
    else if (arm)     follow_q <= 1'b1;
    else if (consume) follow_q <= 1'b0;
  end
endmodule

// File: rtl/bisync_rx_filter.sv
module bisync_rx_filter
  import bisync_rx_filter_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int CTRL_DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hunt_mode,
  input  logic                         char_valid,
  input  logic [CHAR_W-1:0]            char_data,
  input  logic                         dle_enable,
  input  logic [CHAR_W-1:0]            dle_value,
  input  logic                         sync_enable,
  input  logic [CHAR_W-1:0]            sync_value,
  input  logic [CTRL_DEPTH-1:0]        ctrl_valid,
  input  logic [CTRL_DEPTH*CHAR_W-1:0] ctrl_value,
  input  logic [CTRL_DEPTH-1:0]        ctrl_close,
  output logic [CHAR_W-1:0]            out_data,
  output logic                         write_en,
  output logic                         bcs_include,
  output logic                         close_buffer,
  output logic                         dle_follow_error,
  output logic                         ctrl_match
);
  logic     ev_accept;
  logic     ev_arm;
  logic     ev_consume;
  logic     follow_q;
  logic     arm_req;
  logic     tbl_hit;
  logic     tbl_close;
  verdict_t verdict;
  verdict_t verdict_q;

  assign ev_accept  = char_valid && !hunt_mode;
  assign ev_arm     = ev_accept && arm_req;
  assign ev_consume = ev_accept && follow_q;

  bisync_ctrl_table #(.CHAR_W(CHAR_W), .CTRL_DEPTH(CTRL_DEPTH)) table_i (
    .char_data  (char_data),
    .ctrl_valid (ctrl_valid),
    .ctrl_value (ctrl_value),
    .ctrl_close (ctrl_close),
    .tbl_hit    (tbl_hit),
    .tbl_close  (tbl_close)
  );

  bisync_char_classify #(.CHAR_W(CHAR_W)) classify_i (
    .follow      (follow_q),
    .char_data   (char_data),
    .dle_enable  (dle_enable),
    .dle_value   (dle_value),
    .sync_enable (sync_enable),
    .sync_value  (sync_value),
    .tbl_hit     (tbl_hit),
    .tbl_close   (tbl_close),
    .verdict     (verdict),
    .arm_req     (arm_req)
  );

  bisync_follow_state follow_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hunt     (hunt_mode),
    .arm      (ev_arm),
    .consume  (ev_consume),
    .follow_q (follow_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_q <= VERDICT_NONE;
      out_data  <= '0;
    end else if (ev_accept) begin
      verdict_q <= verdict;
      out_data  <= char_data;
    end else begin
      verdict_q <= VERDICT_NONE;
    end
  end

  assign write_en         = verdict_q.keep;
  assign bcs_include      = verdict_q.bcs;
  assign close_buffer     = verdict_q.close;
  assign dle_follow_error = verdict_q.ferr;
  assign ctrl_match       = verdict_q.cmatch;

endmodule

// File: rtl/bisync_rx_filter_chk.sv
module bisync_rx_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic hunt_mode,
  input logic ev_accept,
  input logic ev_arm,
  input logic follow_q,
  input logic write_en,
  input logic bcs_include,
  input logic close_buffer,
  input logic dle_follow_error,
  input logic ctrl_match
);
  AST_FERR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    dle_follow_error |-> (close_buffer && !write_en && !bcs_include)); // R7

  AST_BCS_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bcs_include |-> write_en); // R1

  AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ev_accept) |-> !(write_en || bcs_include || close_buffer ||
                            dle_follow_error || ctrl_match)); // R10

  AST_MATCH_AFTER_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_match |-> $past(follow_q)); // R6

  AST_ARM_SETS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> follow_q); // R3

  AST_ARM_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> (!write_en && !bcs_include)); // R3

  AST_HUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_mode |=> !follow_q); // R11

  AST_FOLLOW_ONE_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (follow_q && ev_accept) |=> !follow_q); // R11
endmodule

bind bisync_rx_filter bisync_rx_filter_chk chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .hunt_mode        (hunt_mode),
  .ev_accept        (ev_accept),
  .ev_arm           (ev_arm),
  .follow_q         (follow_q),
  .write_en         (write_en),
  .bcs_include      (bcs_include),
  .close_buffer     (close_buffer),
  .dle_follow_error (dle_follow_error),
  .ctrl_match       (ctrl_match)
);

// File: tb/bisync_rx_filter_tb.sv
module bisync_rx_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hunt_mode = 1'b0;
  logic         char_valid = 1'b0;
  logic [W-1:0] char_data = '0;
  logic         dle_enable = 1'b0;
  logic [W-1:0] dle_value = '0;
  logic         sync_enable = 1'b0;
  logic [W-1:0] sync_value = '0;
  logic [N-1:0] ctrl_valid = '0;
  logic [N*W-1:0] ctrl_value = '0;
  logic [N-1:0] ctrl_close = '0;
  logic [W-1:0] out_data;
  logic write_en, bcs_include, close_buffer, dle_follow_error, ctrl_match;

  int checks = 0;
  int errors = 0;
  bit mdl_follow = 0;
  bit e_wr, e_bcs, e_cls, e_err, e_cm;
  logic [W-1:0] e_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  bisync_rx_filter #(.CHAR_W(W), .CTRL_DEPTH(N)) dut_i (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference behaviour, written from the requirements.
  task automatic model(input bit r, input bit v, input bit h, input logic [W-1:0] d);
    int hit;
    {e_wr, e_bcs, e_cls, e_err, e_cm} = '0;
    if (!r) begin mdl_follow = 0; e_data = '0; return; end
    if (h) begin mdl_follow = 0; return; end
    if (!v) return;
    e_data = d;
    if (!mdl_follow) begin
      if (sync_enable && d == sync_value) ;
      else if (dle_enable && d == dle_value) mdl_follow = 1;
      else begin e_wr = 1; e_bcs = 1; end
    end else begin
      mdl_follow = 0;
      hit = -1;
      for (int i = 0; i < N; i++)
        if (hit < 0 && ctrl_valid[i] && ctrl_value[i*W +: W] == d) hit = i;
      if (d == sync_value) ;
      else if (d == dle_value) begin e_wr = 1; e_bcs = 1; end
      else if (hit >= 0) begin e_wr = 1; e_bcs = 1; e_cm = 1; e_cls = ctrl_close[hit]; end
      else begin e_cls = 1; e_err = 1; end
    end
  endtask

  task automatic cyc(input bit r, input bit v, input bit h, input logic [W-1:0] d,
                     input string tag);
    rst_n = r; char_valid = v; hunt_mode = h; char_data = d;
    model(r, v, h, d);
    @(negedge clk);
    check(tag, "write_en", write_en, e_wr);
    check(tag, "bcs_include", bcs_include, e_bcs);
    check(tag, "close_buffer", close_buffer, e_cls);
    check(tag, "dle_follow_error", dle_follow_error, e_err);
    check(tag, "ctrl_match", ctrl_match, e_cm);
    if (e_wr || !r) check(tag, "out_data", out_data, e_data);
  endtask

  task automatic put(input logic [W-1:0] d, input string tag);
    cyc(1, 1, 0, d, tag);
  endtask

  task automatic set_entry(input int i, input bit v, input logic [W-1:0] val, input bit c);
    ctrl_valid[i] = v;
    ctrl_value[i*W +: W] = val;
    ctrl_close[i] = c;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] alpha [8] = '{8'h10, 8'h16, 8'h03, 8'h05, 8'h41, 8'h7F, 8'h96, 8'h44};
    @(negedge clk);
    cyc(0, 0, 0, 8'h00, "R12");
    cyc(0, 1, 0, 8'h41, "R12");
    dle_value = 8'h10; dle_enable = 1;
    sync_value = 8'h16; sync_enable = 1;
    set_entry(0, 1, 8'h03, 1);
    set_entry(1, 1, 8'h17, 1);
    set_entry(2, 1, 8'h05, 0);
    set_entry(3, 1, 8'h03, 0);
    set_entry(4, 0, 8'h44, 0);
    set_entry(7, 1, 8'h7F, 0);

    put(8'h41, "R1"); put(8'h42, "R1");
    cyc(1, 0, 0, 8'h41, "R10");
    put(8'h16, "R2");
    put(8'h10, "R3"); put(8'h41, "R7");
    put(8'h10, "R3"); put(8'h10, "R5"); put(8'h10, "R3");
    put(8'h10, "R5");
    put(8'h10, "R3"); put(8'h16, "R4");
    put(8'h10, "R3"); put(8'h03, "R6");
    put(8'h10, "R3"); put(8'h05, "R6");
    put(8'h10, "R3"); put(8'h7F, "R6");
    put(8'h10, "R3"); put(8'h17, "R6");
    put(8'h10, "R3"); put(8'h44, "R7");
    put(8'h03, "R11");
    put(8'h96, "R9"); put(8'h90, "R9");
    put(8'h10, "R3"); put(8'h83, "R9");
    sync_enable = 0;
    put(8'h16, "R8");
    put(8'h10, "R3"); put(8'h16, "R4");
    sync_enable = 1; dle_enable = 0;
    put(8'h10, "R8"); put(8'h03, "R8");
    dle_enable = 1;
    put(8'h10, "R3");
    cyc(1, 1, 1, 8'h41, "R11");
    put(8'h03, "R11");
    put(8'h10, "R3");
    cyc(1, 0, 0, 8'h00, "R10");
    put(8'h03, "R6");
    put(8'h10, "R3");
    cyc(0, 0, 0, 8'h00, "R12");
    put(8'h03, "R12");
    for (int k = 0; k < 400; k++) begin
      cyc(1, $urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0,
          alpha[$urandom_range(0, 7)], "R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule